// File: doc/BRIEF.md
# Clock Controller Start-up Sequencer

This block walks a clock controller from power-on into locked, multiplied operation with no software involved. It acts as a master on a simple request/acknowledge register bus. It reads the chip configuration word and the controller's control word, then keeps a shadow copy of each. It issues each single-bit change to the control word as a separate write of the updated image, so bits it does not own are preserved. Between bus steps it holds timed pauses, and it polls the controller's divider-transition status bit.

The caller places the target multiplier, post-divider, divider ratios and the clock-mode choice on the inputs and pulses `start`. These values are captured on that edge. `busy` stays high until the sequence ends. A normal run ends with a one-cycle `done` pulse after the final write that takes the controller out of bypass. If a status poll never reads idle, the run ends with `error` set instead, and the bypass is never left.

Top module: `clkgen_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `bus_req` are all 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. The first transfer is then a read of the configuration word at address 0x40, followed by a write of that word with bit 4 (lock indication) cleared.
- R3: The control word at 0x10 is read once and then written as successive images. The images are: clear bit 5 (enable source), clear bit 9 (external source), clear bit 0 (enable, giving bypass), put `clk_mode` into bit 8, clear bit 3 (reset release), set bit 4 (output disable), clear bit 1 (power-down), clear bit 4. Every other bit keeps the value that was read.
- R4: Each timed pause adds exactly its parameter count of cycles between the acknowledges of the transfers on either side. There are four pauses: MUX_WAIT after bypass, STAB_WAIT after power-up, RST_WAIT after the GO handshake and LOCK_WAIT after reset release. Back-to-back transfers are acknowledged 2 cycles apart.
- R5: After the stabilisation pause, the multiplier is written to 0x11 as a plain value. The post-divider is then written to 0x12 with bit 15 set.
- R6: Before any divider write, the status word at 0x13 is read repeatedly until its bit 0 (GO in progress) reads 0.
- R7: Dividers go to address 0x20+n, each with bit 15 set, in the order 1, 2, 4, 6, 3, 7. Divider 4 carries ((div1+1)*4)-1 and divider 6 carries div1.
- R8: After the dividers, the value 1 is written to the command word at 0x14 (GO). Status is then polled again until bit 0 reads 0.
- R9: After the reset pause, bit 3 of the control word is set. After the lock pause, bit 0 is set. `done` is high for exactly the one cycle after that write is acknowledged, with `busy` already 0.
- R10: If POLL_LIMIT consecutive status reads in one poll step show bit 0 set, `error` rises and `busy` falls. No further transfer is made, so the controller is neither released nor enabled. A later `start` clears `error`.
- R11: A `start` pulse while busy is ignored, and input changes after the starting edge have no effect. The transfer stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (idle only) |
| clk_mode | input | 1 | Target clock-mode bit |
| mult | input | MULT_W | Target multiplier |
| post_div | input | RATIO_W | Target post-divider ratio |
| div1 | input | RATIO_W | Divider 1 ratio (also feeds dividers 4 and 6) |
| div2 | input | RATIO_W | Divider 2 ratio |
| div3 | input | RATIO_W | Divider 3 ratio |
| div7 | input | RATIO_W | Divider 7 ratio |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Poll timeout seen; held until next start |
| bus_req | output | 1 | Transfer request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer complete in this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The hardest conditions to reach are the status polls that hit exactly POLL_LIMIT-1 busy readings and those that hit exactly POLL_LIMIT. From the block's side these differ only in one status read. The bench's register model is loaded with separate busy-read counts for the poll before the dividers and for the poll after the GO command. It then runs one case that just survives each poll and one that times out in each. A start pulse with changed targets is also injected midway through a run, and the scoreboard shows the transfer stream was unaffected.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int STEP_W = 5;
  localparam int STEP_LAST = 27;

  localparam logic [ADDR_W-1:0] A_CTL     = 8'h10;
  localparam logic [ADDR_W-1:0] A_MULT    = 8'h11;
  localparam logic [ADDR_W-1:0] A_POSTDIV = 8'h12;
  localparam logic [ADDR_W-1:0] A_STAT    = 8'h13;
  localparam logic [ADDR_W-1:0] A_CMD     = 8'h14;
  localparam logic [ADDR_W-1:0] A_DIVBASE = 8'h20;
  localparam logic [ADDR_W-1:0] A_CFG     = 8'h40;

  localparam int B_EN      = 0;
  localparam int B_PWRDN   = 1;
  localparam int B_RSTREL  = 3;
  localparam int B_OUTDIS  = 4;
  localparam int B_ENSRC   = 5;
  localparam int B_CLKMODE = 8;
  localparam int B_EXTSRC  = 9;
  localparam int B_LOCK    = 4;
  localparam int B_GO      = 0;
  localparam int B_RATIOEN = 15;

  typedef enum logic [2:0] {OP_READ, OP_RMW, OP_WRITE, OP_WAIT, OP_POLL} op_kind_e;
  typedef enum logic [1:0] {W_MUX, W_STAB, W_RST, W_LOCK} wait_sel_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] clr;
    wait_sel_e         wsel;
  } step_t;

  function automatic logic [DATA_W-1:0] bitmask(input int pos);
    return DATA_W'(1) << pos;
  endfunction

  function automatic logic [DATA_W-1:0] ratio_word(input logic [14:0] r);
    logic [DATA_W-1:0] w;
    w = DATA_W'(r);
    w[B_RATIOEN] = 1'b1;
    return w;
  endfunction

  function automatic logic [14:0] div4_ratio(input logic [14:0] d1);
    return ((d1 + 15'd1) << 2) - 15'd1;
  endfunction

  function automatic logic [DATA_W-1:0] rmw(input logic [DATA_W-1:0] img,
                                             input logic [DATA_W-1:0] clr,
                                             input logic [DATA_W-1:0] set);
    return (img & ~clr) | set;
  endfunction

endpackage

// File: rtl/bringup_step_rom.sv
module bringup_step_rom
  import bringup_pkg::*;
#(
  parameter int RATIO_W = 5,
  parameter int MULT_W  = 5
) (
  input  logic [STEP_W-1:0]  step,
  input  logic               clk_mode,
  input  logic [MULT_W-1:0]  mult,
  input  logic [RATIO_W-1:0] post_div,
  input  logic [RATIO_W-1:0] div1,
  input  logic [RATIO_W-1:0] div2,
  input  logic [RATIO_W-1:0] div3,
  input  logic [RATIO_W-1:0] div7,
  output step_t              op
);

  logic [14:0] d1_x;
  assign d1_x = 15'(div1);

  function automatic step_t mk(input op_kind_e k, input logic [ADDR_W-1:0] a,
                               input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] c,
                               input wait_sel_e w);
    step_t s;
    s.kind = k; s.addr = a; s.data = d; s.clr = c; s.wsel = w;
    return s;
  endfunction

  always_comb begin
    unique case (step)
      5'd0:  op = mk(OP_READ,  A_CFG, '0, '0, W_MUX);
      5'd1:  op = mk(OP_RMW,   A_CFG, '0, bitmask(B_LOCK), W_MUX);
      5'd2:  op = mk(OP_READ,  A_CTL, '0, '0, W_MUX);
      5'd3:  op = mk(OP_RMW,   A_CTL, '0, bitmask(B_ENSRC), W_MUX);
      5'd4:  op = mk(OP_RMW,   A_CTL, '0, bitmask(B_EXTSRC), W_MUX);
      5'd5:  op = mk(OP_RMW,   A_CTL, '0, bitmask(B_EN), W_MUX);
      5'd6:  op = mk(OP_WAIT,  A_CTL, '0, '0, W_MUX);
      5'd7:  op = mk(OP_RMW,   A_CTL, DATA_W'(clk_mode) << B_CLKMODE,
                     bitmask(B_CLKMODE), W_MUX);
      5'd8:  op = mk(OP_RMW,   A_CTL, '0, bitmask(B_RSTREL), W_MUX);
      5'd9:  op = mk(OP_RMW,   A_CTL, bitmask(B_OUTDIS), '0, W_MUX);
      5'd10: op = mk(OP_RMW,   A_CTL, '0, bitmask(B_PWRDN), W_MUX);
      5'd11: op = mk(OP_RMW,   A_CTL, '0, bitmask(B_OUTDIS), W_MUX);
      5'd12: op = mk(OP_WAIT,  A_CTL, '0, '0, W_STAB);
      5'd13: op = mk(OP_WRITE, A_MULT, DATA_W'(mult), '0, W_MUX);
      5'd14: op = mk(OP_WRITE, A_POSTDIV, ratio_word(15'(post_div)), '0, W_MUX);
      5'd15: op = mk(OP_POLL,  A_STAT, '0, '0, W_MUX);
      5'd16: op = mk(OP_WRITE, A_DIVBASE + 8'd1, ratio_word(d1_x), '0, W_MUX);
      5'd17: op = mk(OP_WRITE, A_DIVBASE + 8'd2, ratio_word(15'(div2)), '0, W_MUX);
      5'd18: op = mk(OP_WRITE, A_DIVBASE + 8'd4, ratio_word(div4_ratio(d1_x)), '0, W_MUX);
      5'd19: op = mk(OP_WRITE, A_DIVBASE + 8'd6, ratio_word(d1_x), '0, W_MUX);
      5'd20: op = mk(OP_WRITE, A_DIVBASE + 8'd3, ratio_word(15'(div3)), '0, W_MUX);
      5'd21: op = mk(OP_WRITE, A_DIVBASE + 8'd7, ratio_word(15'(div7)), '0, W_MUX);
      5'd22: op = mk(OP_WRITE, A_CMD, DATA_W'(1), '0, W_MUX);
      5'd23: op = mk(OP_POLL,  A_STAT, '0, '0, W_MUX);
      5'd24: op = mk(OP_WAIT,  A_CTL, '0, '0, W_RST);
      5'd25: op = mk(OP_RMW,   A_CTL, bitmask(B_RSTREL), '0, W_MUX);
      5'd26: op = mk(OP_WAIT,  A_CTL, '0, '0, W_LOCK);
      5'd27: op = mk(OP_RMW,   A_CTL, bitmask(B_EN), '0, W_MUX);
      default: op = mk(OP_WAIT, A_CTL, '0, '0, W_MUX);
    endcase
  end

endmodule

// File: rtl/bringup_timer.sv
module bringup_timer
  import bringup_pkg::*;
#(
  parameter int MUX_WAIT  = 4,
  parameter int STAB_WAIT = 64,
  parameter int RST_WAIT  = 32,
  parameter int LOCK_WAIT = 200
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  wait_sel_e wsel,
  output logic      expired
);

  localparam int MAX_A = (MUX_WAIT > STAB_WAIT) ? MUX_WAIT : STAB_WAIT;
  localparam int MAX_B = (RST_WAIT > LOCK_WAIT) ? RST_WAIT : LOCK_WAIT;
  localparam int MAXW  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXW + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt;

  always_comb begin
    unique case (wsel)
      W_MUX:   tgt = CW'(MUX_WAIT);
      W_STAB:  tgt = CW'(STAB_WAIT);
      W_RST:   tgt = CW'(RST_WAIT);
      default: tgt = CW'(LOCK_WAIT);
    endcase
  end

  assign expired = active && (cnt_q == tgt - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!active || expired) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  // R4: the pause counter never passes its selected length
  p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt_q < tgt);

endmodule

// File: rtl/bringup_poll_guard.sv
module bringup_poll_guard #(
  parameter int POLL_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic seen_busy,
  output logic timeout
);

  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign timeout = seen_busy && (cnt_q == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!active)    cnt_q <= '0;
    else if (seen_busy)  cnt_q <= cnt_q + CW'(1);
  end

  // R10: busy readings in one poll step stay below the limit while polling
  p_poll_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt_q < CW'(POLL_LIMIT));

endmodule

// File: rtl/clkgen_bringup_seq.sv
module clkgen_bringup_seq
  import bringup_pkg::*;
#(
  parameter int RATIO_W    = 5,
  parameter int MULT_W     = 5,
  parameter int MUX_WAIT   = 4,
  parameter int STAB_WAIT  = 64,
  parameter int RST_WAIT   = 32,
  parameter int LOCK_WAIT  = 200,
  parameter int POLL_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               clk_mode,
  input  logic [MULT_W-1:0]  mult,
  input  logic [RATIO_W-1:0] post_div,
  input  logic [RATIO_W-1:0] div1,
  input  logic [RATIO_W-1:0] div2,
  input  logic [RATIO_W-1:0] div3,
  input  logic [RATIO_W-1:0] div7,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               bus_req,
  output logic               bus_we,
  output logic [7:0]         bus_addr,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic [31:0]        bus_rdata
);

  logic               busy_q, done_q, err_q;
  logic [STEP_W-1:0]  step_q;
  logic [DATA_W-1:0]  shadow_q;
  logic               mode_q;
  logic [MULT_W-1:0]  mult_q;
  logic [RATIO_W-1:0] post_q, d1_q, d2_q, d3_q, d7_q;
  step_t              op;

  // named internal events
  logic xfer, poll_clear, wait_expired, poll_timeout, advance, last_step;

  bringup_step_rom #(.RATIO_W(RATIO_W), .MULT_W(MULT_W)) u_rom (
    .step(step_q), .clk_mode(mode_q), .mult(mult_q), .post_div(post_q),
    .div1(d1_q), .div2(d2_q), .div3(d3_q), .div7(d7_q), .op(op)
  );

  bringup_timer #(.MUX_WAIT(MUX_WAIT), .STAB_WAIT(STAB_WAIT),
                  .RST_WAIT(RST_WAIT), .LOCK_WAIT(LOCK_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(busy_q && op.kind == OP_WAIT),
    .wsel(op.wsel), .expired(wait_expired)
  );

  bringup_poll_guard #(.POLL_LIMIT(POLL_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .active(busy_q && op.kind == OP_POLL),
    .seen_busy(xfer && op.kind == OP_POLL && bus_rdata[B_GO]),
    .timeout(poll_timeout)
  );

  assign bus_req   = busy_q && (op.kind != OP_WAIT);
  assign bus_we    = (op.kind == OP_RMW) || (op.kind == OP_WRITE);
  assign bus_addr  = op.addr;
  assign bus_wdata = (op.kind == OP_RMW)   ? rmw(shadow_q, op.clr, op.data) :
                     (op.kind == OP_WRITE) ? op.data : '0;

  assign xfer       = bus_req && bus_ack;
  assign poll_clear = xfer && (op.kind == OP_POLL) && !bus_rdata[B_GO];
  assign advance    = (xfer && op.kind != OP_POLL) || poll_clear || wait_expired;
  assign last_step  = (step_q == STEP_W'(STEP_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      step_q   <= '0;
      shadow_q <= '0;
      mode_q   <= 1'b0;
      mult_q   <= '0;
      post_q   <= '0;
      d1_q     <= '0;
      d2_q     <= '0;
      d3_q     <= '0;
      d7_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          err_q  <= 1'b0;
          step_q <= '0;
          mode_q <= clk_mode;
          mult_q <= mult;
          post_q <= post_div;
          d1_q   <= div1;
          d2_q   <= div2;
          d3_q   <= div3;
          d7_q   <= div7;
        end
      end else if (poll_timeout) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        if (xfer && op.kind == OP_READ) shadow_q <= bus_rdata;
        if (xfer && op.kind == OP_RMW)  shadow_q <= bus_wdata;
        if (advance) begin
          if (last_step) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign error = err_q;

  // R3: a pending request keeps its address and data until acknowledged
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_wdata));

  // R11: while running the step index only holds or moves forward by one
  p_step_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q || step_q == $past(step_q)
               || step_q == $past(step_q) + STEP_W'(1));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion is reported only once idle and without error
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !error);

  // R10: after a timeout no transfer is requested
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !bus_req);

endmodule

// File: tb/clkgen_bringup_seq_test.sv
module clkgen_bringup_seq_test;

  localparam int MUXW = 4, STABW = 10, RSTW = 7, LOCKW = 12, PLIM = 6;
  localparam logic [7:0] A_CTL = 8'h10, A_MULT = 8'h11, A_POST = 8'h12,
                         A_STAT = 8'h13, A_CMD = 8'h14, A_CFG = 8'h40;

  logic clk = 0, rst_n = 0, start = 0, clk_mode = 0;
  logic [4:0] mult = 0, post_div = 0, div1 = 0, div2 = 0, div3 = 0, div7 = 0;
  logic busy, done, error, bus_req, bus_we, bus_ack = 0;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = 0;

  always #2 clk = ~clk;

  clkgen_bringup_seq #(.MUX_WAIT(MUXW), .STAB_WAIT(STABW), .RST_WAIT(RSTW),
                       .LOCK_WAIT(LOCKW), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_mode(clk_mode), .mult(mult),
    .post_div(post_div), .div1(div1), .div2(div2), .div3(div3), .div7(div7),
    .busy(busy), .done(done), .error(error), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int total = 0, bad = 0, cyc = 0, last_ack = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // register model
  logic [31:0] ctl_m, cfg_m, ctl_seed, cfg_seed;
  int go_left, pre_seed, go_seed;
  logic load = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_ack <= bus_req && !bus_ack;
    if (load) begin
      ctl_m <= ctl_seed; cfg_m <= cfg_seed; go_left <= pre_seed;
    end else if (bus_req && !bus_ack) begin
      if (bus_we) begin
        if (bus_addr == A_CTL) ctl_m <= bus_wdata;
        if (bus_addr == A_CFG) cfg_m <= bus_wdata;
        if (bus_addr == A_CMD) go_left <= go_seed;
      end else begin
        if (bus_addr == A_CTL) bus_rdata <= ctl_m;
        else if (bus_addr == A_CFG) bus_rdata <= cfg_m;
        else if (bus_addr == A_STAT) begin
          bus_rdata <= {31'b0, go_left != 0};
          if (go_left != 0) go_left <= go_left - 1;
        end else bus_rdata <= 32'h0;
      end
    end
  end

  // scoreboard
  typedef struct { logic we; logic [7:0] addr; logic [31:0] data; int gap; string req; } exp_t;
  exp_t exp_q[$];

  task automatic push(input logic we, input logic [7:0] a, input logic [31:0] d, input int gap, input string req);
    exp_t e;
    e.we = we; e.addr = a; e.data = d; e.gap = gap; e.req = req;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_req && bus_ack) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10/R11 unexpected transfer", {24'h0, bus_addr}, 32'hffffffff);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(bus_we == e.we && bus_addr == e.addr, e.req, {23'h0, bus_we, bus_addr}, {23'h0, e.we, e.addr});
        if (e.we) chk(bus_wdata == e.data, e.req, bus_wdata, e.data);
        if (e.gap != 0) chk(cyc - last_ack == e.gap, {e.req, " R4 spacing"}, cyc - last_ack, e.gap);
      end
      last_ack = cyc;
    end
  end

  // driver: builds the expected transfer list; returns 1 if a timeout is expected
  task automatic build(input logic [31:0] cfg0, input logic [31:0] ctl0, input logic cm,
                       input logic [4:0] m, input logic [4:0] pd, input logic [4:0] a1,
                       input logic [4:0] a2, input logic [4:0] a3, input logic [4:0] a7,
                       input int pre, input int go, output bit err_exp);
    logic [31:0] c;
    err_exp = 0;
    push(0, A_CFG, 0, 0, "R2 cfg read");
    push(1, A_CFG, cfg0 & ~32'h10, 2, "R2 lock clear");
    push(0, A_CTL, 0, 2, "R3 ctl read");
    c = ctl0;
    c[5] = 0; push(1, A_CTL, c, 2, "R3 ensrc");
    c[9] = 0; push(1, A_CTL, c, 2, "R3 extsrc");
    c[0] = 0; push(1, A_CTL, c, 2, "R3 bypass");
    c[8] = cm; push(1, A_CTL, c, MUXW + 2, "R3 clkmode R4");
    c[3] = 0; push(1, A_CTL, c, 2, "R3 reset");
    c[4] = 1; push(1, A_CTL, c, 2, "R3 outdis set");
    c[1] = 0; push(1, A_CTL, c, 2, "R3 powerup");
    c[4] = 0; push(1, A_CTL, c, 2, "R3 outdis clr");
    push(1, A_MULT, {27'h0, m}, STABW + 2, "R5 mult R4");
    push(1, A_POST, 32'h8000 | pd, 2, "R5 postdiv");
    for (int i = 0; i <= pre && i < PLIM; i++) push(0, A_STAT, 0, 2, "R6 poll");
    if (pre >= PLIM) begin err_exp = 1; return; end
    push(1, 8'h21, 32'h8000 | a1, 2, "R7 div1");
    push(1, 8'h22, 32'h8000 | a2, 2, "R7 div2");
    push(1, 8'h24, 32'h8000 | (((a1 + 32'd1) * 4) - 1), 2, "R7 div4");
    push(1, 8'h26, 32'h8000 | a1, 2, "R7 div6");
    push(1, 8'h23, 32'h8000 | a3, 2, "R7 div3");
    push(1, 8'h27, 32'h8000 | a7, 2, "R7 div7");
    push(1, A_CMD, 32'h1, 2, "R8 go");
    for (int i = 0; i <= go && i < PLIM; i++) push(0, A_STAT, 0, 2, "R8 poll");
    if (go >= PLIM) begin err_exp = 1; return; end
    c[3] = 1; push(1, A_CTL, c, RSTW + 2, "R9 release R4");
    c[0] = 1; push(1, A_CTL, c, LOCKW + 2, "R9 enable R4");
  endtask

  task automatic run_case(input logic [31:0] cfg0, input logic [31:0] ctl0, input logic cm,
                          input logic [4:0] m, input logic [4:0] pd, input logic [4:0] a1,
                          input logic [4:0] a2, input logic [4:0] a3, input logic [4:0] a7,
                          input int pre, input int go, input bit glitch);
    bit err_exp, fin;
    build(cfg0, ctl0, cm, m, pd, a1, a2, a3, a7, pre, go, err_exp);
    @(negedge clk);
    cfg_seed = cfg0; ctl_seed = ctl0; pre_seed = pre; go_seed = go; load = 1;
    @(negedge clk);
    load = 0;
    clk_mode = cm; mult = m; post_div = pd; div1 = a1; div2 = a2; div3 = a3; div7 = a7;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1 && bus_req == 1 && bus_addr == A_CFG && bus_we == 0, "R2 start",
        {busy, bus_req, bus_we, 21'h0, bus_addr}, {3'b110, 21'h0, A_CFG});
    fin = 0;
    for (int k = 0; k < 3000 && !fin; k++) begin
      @(negedge clk);
      if (glitch && k == 30) begin start = 1; mult = ~m; div1 = ~a1; clk_mode = ~cm; end
      if (glitch && k == 31) start = 0;
      if (done || error) fin = 1;
    end
    if (err_exp) begin
      chk(error == 1 && busy == 0 && done == 0, "R10 timeout flag", {error, busy, done}, 3'b100);
    end else begin
      chk(done == 1 && busy == 0 && error == 0, "R9 done", {done, busy, error}, 3'b100);
      chk(cyc == last_ack + 1, "R9 done timing", cyc, last_ack + 1);
      @(negedge clk);
      chk(done == 0, "R9 done one cycle", done, 0);
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected transfers seen", exp_q.size(), 0);
    chk(bus_req == 0 && busy == 0, "R10/R9 quiet after end", {bus_req, busy}, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && error == 0 && bus_req == 0, "R1 reset",
        {busy, done, error, bus_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && bus_req == 0, "R1 idle after reset", {busy, bus_req}, 0);
    // plain run, preserved high bits in control word
    run_case(32'h33, 32'h0000_F2A3, 1, 5'd24, 5'd1, 5'd0, 5'd1, 5'd4, 5'd9, 0, 2, 0);
    // limit-1 busy polls both times, div1 max, start glitch mid-run (R11)
    run_case(32'h10, 32'h0000_0132, 0, 5'd31, 5'd3, 5'd31, 5'd7, 5'd2, 5'd30, PLIM - 1, PLIM - 1, 1);
    // timeout in pre-divider poll (R10)
    run_case(32'hFF, 32'h0000_033B, 1, 5'd5, 5'd0, 5'd2, 5'd3, 5'd4, 5'd5, PLIM, 0, 0);
    // timeout after GO (R10): no release, no enable
    run_case(32'h00, 32'h0000_0223, 0, 5'd9, 5'd2, 5'd6, 5'd1, 5'd1, 5'd1, 1, PLIM, 0);
    // recovery after error
    run_case(32'h1F, 32'h8000_0FFF, 1, 5'd17, 5'd4, 5'd3, 5'd5, 5'd11, 5'd13, 2, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule